// File: doc/BRIEF.md
# General-Purpose Pin Controller with Interrupt Detection

This block drives and samples a bank of general-purpose pins from a simple memory-mapped register bus. The bus has a byte address, a write strobe, write data and read data that is returned combinationally. Software can write the output word directly or change single bits without a read-modify-write, using one register that sets bits and another that clears them. A direction word chooses which pins drive, and the input word always shows the synchronized pin levels. Pull enable, pull select and a filter-skip word are plain storage that drive outputs toward the pad ring.

Each pin has its own event detector, set by three bit planes: sense mode (level or edge), polarity, and any-edge. An edge event is latched until software writes a one to that pin's bit in the acknowledge register. A level-sensed pin reports its live qualified level. The raw events are qualified by the interrupt mask to give a masked status word, and a single interrupt line is the OR of that masked word.

Top module: `pin_ctrl_irq`

## Requirements
- R1: After reset every stored register reads zero, the driven outputs are zero and `irq_o` is low.
- R2: A write to the output word at 0x00 replaces `pin_out`, and the value reads back at 0x00.
- R3: A write to 0x10 sets each output bit where the data bit is one. A write to 0x14 clears each output bit where the data bit is one. Zero data bits leave output bits unchanged. Both addresses read as zero.
- R4: The direction word at 0x08 drives `pin_oe`, where 1 means the pin drives. The input word at 0x04 returns `pin_in` two clocks after it changes, whatever the direction is.
- R5: The pull enable (0x18), pull select (0x1C) and filter-skip (0x0C) words are read/write storage that drive `pull_en`, `pull_sel` and `filter_skip`.
- R6: When the mode bit (0x34) is 1, a pin is level sensed. Its raw status is the live synchronized level, active high when the polarity bit (0x3C) is 0 and active low when it is 1. Writing the acknowledge register does not change it.
- R7: When the mode bit is 0 and the any-edge bit (0x38) is 0, a polarity bit of 0 latches an event on a rising edge only, and a polarity bit of 1 latches an event on a falling edge only.
- R8: When the mode bit is 0 and the any-edge bit is 1, both rising and falling edges latch an event.
- R9: Writing the acknowledge register (0x30) clears the latched edge event of each pin whose data bit is one. Other pins are left as they were, and all ones clears every pin.
- R10: A pin whose enable bit (0x20) is 0 raises no raw status, in level or edge mode.
- R11: Masked status (0x28) is the raw status (0x24) with bits removed where the mask (0x2C) is 1. `irq_o` is high exactly when masked status is nonzero.
- R12: Writes to the read-only words (0x04, 0x24, 0x28) and writes at addresses with nonzero low two bits change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output data toward the pads |
| pin_oe | output | NPINS | Per-pin drive enable |
| pull_en | output | NPINS | Pull resistor enable storage |
| pull_sel | output | NPINS | Pull direction select storage |
| filter_skip | output | NPINS | Input filter bypass storage |
| irq_o | output | 1 | Combined interrupt, OR of masked status |

## Verification
The assertions assume that a write strobe is held for exactly one clock with a stable address and data. They also assume that only the two-flop synchronizer samples the pins, so the edge checks reason only about synchronized samples. The bench changes every bus input and pin on the falling clock edge and holds each pin level for at least four clocks, so every edge is seen before the next one arrives. Mode, polarity and enable bits are programmed while the affected pins are quiet, so reconfiguration never creates an event the bench does not expect.

// File: rtl/pinio_pkg.sv
package pinio_pkg;
  // word index = byte address [5:2]; software-visible, so kept fixed
  typedef enum logic [3:0] {
    W_OUT   = 4'h0, W_IN    = 4'h1, W_DIR   = 4'h2, W_SKIP  = 4'h3,
    W_SET   = 4'h4, W_CLR   = 4'h5, W_PEN   = 4'h6, W_PSEL  = 4'h7,
    W_IEN   = 4'h8, W_RAW   = 4'h9, W_MSKD  = 4'hA, W_MASK  = 4'hB,
    W_ACK   = 4'hC, W_MODE  = 4'hD, W_ANY   = 4'hE, W_POL   = 4'hF
  } word_sel_e;
endpackage

// File: rtl/pinio_sync.sv
module pinio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pinio_detect.sv
module pinio_detect (
  input  logic clk,
  input  logic rst_ni,
  input  logic smp_i,      // synchronized pin level
  input  logic en_i,       // detector enable
  input  logic lvl_mode_i, // 1: level, 0: edge
  input  logic pol_i,      // level: 1 active-low; edge: 1 falling
  input  logic any_i,      // edge: both edges
  input  logic ack_i,      // acknowledge strobe for this pin
  output logic raw_o
);
  logic smp_d_q;
  logic latch_q, latch_d;
  logic rise_w, fall_w, edge_hit;

  assign rise_w = smp_i & ~smp_d_q;
  assign fall_w = ~smp_i & smp_d_q;

  always_comb begin
    if (any_i)      edge_hit = rise_w | fall_w;
    else if (pol_i) edge_hit = fall_w;
    else            edge_hit = rise_w;
    edge_hit = edge_hit & en_i & ~lvl_mode_i;
    latch_d  = edge_hit | (latch_q & ~ack_i & ~lvl_mode_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_d_q <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      smp_d_q <= smp_i;
      latch_q <= latch_d;
    end
  end

  assign raw_o = lvl_mode_i ? (en_i & (smp_i ^ pol_i)) : latch_q;

  p_rise_latch_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && !lvl_mode_i && !any_i && !pol_i && smp_i && !smp_d_q) |=> latch_q);
  p_any_latch_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && !lvl_mode_i && any_i && (smp_i != smp_d_q)) |=> latch_q);
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && !en_i) |=> !latch_q);
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en_i && !latch_q) |=> !latch_q);
  p_lvl_off_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (lvl_mode_i && !en_i) |-> !raw_o);
endmodule

// File: rtl/pin_ctrl_irq.sv
module pin_ctrl_irq #(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pull_en,
  output logic [NPINS-1:0]  pull_sel,
  output logic [NPINS-1:0]  filter_skip,
  output logic              irq_o
);
  import pinio_pkg::*;

  localparam int SYNC_STAGES = 2;
  localparam int IDX_W       = 4;

  // reset: asserted asynchronously, released after two clocks
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // decode
  logic             aligned;
  word_sel_e        sel;
  logic [NPINS-1:0] wd;
  logic             wr_hit;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign sel     = word_sel_e'(bus_addr[IDX_W+1:2]);
  assign wd      = bus_wdata[NPINS-1:0];
  assign wr_hit  = bus_wr & aligned;

  // storage
  logic [NPINS-1:0] out_q, dir_q, skip_q, pen_q, psel_q, ien_q, mask_q, mode_q, any_q, pol_q;
  logic [NPINS-1:0] out_d, dir_d, skip_d, pen_d, psel_d, ien_d, mask_d, mode_d, any_d, pol_d;

  always_comb begin
    out_d = out_q;   dir_d = dir_q;   skip_d = skip_q; pen_d = pen_q;  psel_d = psel_q;
    ien_d = ien_q;   mask_d = mask_q; mode_d = mode_q; any_d = any_q;  pol_d = pol_q;
    if (wr_hit) begin
      unique case (sel)
        W_OUT:  out_d  = wd;
        W_SET:  out_d  = out_q | wd;
        W_CLR:  out_d  = out_q & ~wd;
        W_DIR:  dir_d  = wd;
        W_SKIP: skip_d = wd;
        W_PEN:  pen_d  = wd;
        W_PSEL: psel_d = wd;
        W_IEN:  ien_d  = wd;
        W_MASK: mask_d = wd;
        W_MODE: mode_d = wd;
        W_ANY:  any_d  = wd;
        W_POL:  pol_d  = wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_q <= '0; dir_q <= '0; skip_q <= '0; pen_q <= '0; psel_q <= '0;
      ien_q <= '0; mask_q <= '0; mode_q <= '0; any_q <= '0; pol_q <= '0;
    end else if (wr_hit) begin
      out_q <= out_d; dir_q <= dir_d; skip_q <= skip_d; pen_q <= pen_d; psel_q <= psel_d;
      ien_q <= ien_d; mask_q <= mask_d; mode_q <= mode_d; any_q <= any_d; pol_q <= pol_d;
    end
  end

  // input path and detectors
  logic [NPINS-1:0] smp_w, raw_w, mskd_w;
  logic             ack_hit;

  pinio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .d_i    (pin_in),
    .q_o    (smp_w)
  );

  assign ack_hit = wr_hit & (sel == W_ACK);

  for (genvar i = 0; i < NPINS; i++) begin : g_det
    pinio_detect u_det (
      .clk        (clk),
      .rst_ni     (rst_sync_n),
      .smp_i      (smp_w[i]),
      .en_i       (ien_q[i]),
      .lvl_mode_i (mode_q[i]),
      .pol_i      (pol_q[i]),
      .any_i      (any_q[i]),
      .ack_i      (ack_hit & wd[i]),
      .raw_o      (raw_w[i])
    );
  end

  assign mskd_w = raw_w & ~mask_q;
  assign irq_o  = |mskd_w;

  // read mux
  logic [NPINS-1:0] rd_vec;
  always_comb begin
    unique case (sel)
      W_OUT:  rd_vec = out_q;
      W_IN:   rd_vec = smp_w;
      W_DIR:  rd_vec = dir_q;
      W_SKIP: rd_vec = skip_q;
      W_PEN:  rd_vec = pen_q;
      W_PSEL: rd_vec = psel_q;
      W_IEN:  rd_vec = ien_q;
      W_RAW:  rd_vec = raw_w;
      W_MSKD: rd_vec = mskd_w;
      W_MASK: rd_vec = mask_q;
      W_MODE: rd_vec = mode_q;
      W_ANY:  rd_vec = any_q;
      W_POL:  rd_vec = pol_q;
      default: rd_vec = '0;
    endcase
    bus_rdata = '0;
    if (aligned) bus_rdata[NPINS-1:0] = rd_vec;
  end

  assign pin_out     = out_q;
  assign pin_oe      = dir_q;
  assign pull_en     = pen_q;
  assign pull_sel    = psel_q;
  assign filter_skip = skip_q;

  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == ADDR_W'(8'h10)) |=> ((pin_out & $past(wd)) == $past(wd)));
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == ADDR_W'(8'h14)) |=> ((pin_out & $past(wd)) == '0));
  p_dir_write_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == ADDR_W'(8'h08)) |=> (pin_oe == $past(wd)));
  p_full_mask_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (&mask_q) |-> !irq_o);
  p_misaligned_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr[1:0] != 2'b00) |=> $stable(pin_out) && $stable(pin_oe));
endmodule

// File: tb/sim_pin_ctrl_irq.sv
module sim_pin_ctrl_irq;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pull_en, pull_sel, filter_skip;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_ctrl_irq #(.NPINS(NP), .DATA_W(32), .ADDR_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en), .pull_sel(pull_sel),
    .filter_skip(filter_skip), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] m, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v & m, exp);
  endtask

  task automatic drive_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  // {write, addr, data, expected read, requirement}
  localparam int NV = 22;
  localparam logic [74:0] VEC [NV] = '{
    {1'b1, 6'h00, 32'hA5A5_0F0F, 32'h0,          4'd2},  // R2 write
    {1'b0, 6'h00, 32'h0,         32'hA5A5_0F0F, 4'd2},
    {1'b1, 6'h10, 32'h0000_00F0, 32'h0,          4'd3},  // R3 set
    {1'b0, 6'h00, 32'h0,         32'hA5A5_0FFF, 4'd3},
    {1'b1, 6'h14, 32'hA000_000F, 32'h0,          4'd3},  // R3 clear
    {1'b0, 6'h00, 32'h0,         32'h05A5_0FF0, 4'd3},
    {1'b0, 6'h10, 32'h0,         32'h0,          4'd3},
    {1'b0, 6'h14, 32'h0,         32'h0,          4'd3},
    {1'b1, 6'h08, 32'hFFFF_0000, 32'h0,          4'd4},  // R4
    {1'b0, 6'h08, 32'h0,         32'hFFFF_0000, 4'd4},
    {1'b1, 6'h18, 32'h1234_5678, 32'h0,          4'd5},  // R5
    {1'b0, 6'h18, 32'h0,         32'h1234_5678, 4'd5},
    {1'b1, 6'h1C, 32'h8765_4321, 32'h0,          4'd5},
    {1'b0, 6'h1C, 32'h0,         32'h8765_4321, 4'd5},
    {1'b1, 6'h0C, 32'h0F0F_F0F0, 32'h0,          4'd5},
    {1'b0, 6'h0C, 32'h0,         32'h0F0F_F0F0, 4'd5},
    {1'b1, 6'h24, 32'hFFFF_FFFF, 32'h0,          4'd12}, // R12 read-only
    {1'b0, 6'h24, 32'h0,         32'h0,          4'd12},
    {1'b1, 6'h01, 32'hFFFF_FFFF, 32'h0,          4'd12}, // misaligned
    {1'b0, 6'h00, 32'h0,         32'h05A5_0FF0, 4'd12},
    {1'b1, 6'h0A, 32'h0000_0000, 32'h0,          4'd12},
    {1'b0, 6'h08, 32'h0,         32'hFFFF_0000, 4'd12}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 16; a++) rd_chk("R1 reset read", 6'(a*4), 32'hFFFF_FFFF, 32'h0);
    check("R1 outputs", pin_out | pin_oe | pull_en | pull_sel | filter_skip, 32'h0);
    check("R1 irq", {31'd0, irq_o}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][74]) wr(VEC[i][73:68], VEC[i][67:36]);
      else rd_chk($sformatf("R%0d table %0d", VEC[i][3:0], i), VEC[i][73:68], 32'hFFFF_FFFF, VEC[i][35:4]);
    end
    check("R2 pin_out", pin_out, 32'h05A5_0FF0);
    check("R4 pin_oe", pin_oe, 32'hFFFF_0000);
    check("R5 pull_en", pull_en, 32'h1234_5678);
    check("R5 pull_sel", pull_sel, 32'h8765_4321);
    check("R5 filter_skip", filter_skip, 32'h0F0F_F0F0);

    // R4: input sampled regardless of direction, two-clock latency
    @(negedge clk); pin_in = 32'hDEAD_BEE0; bus_addr = 6'h04;
    @(negedge clk); #1 check("R4 input not yet visible", bus_rdata, 32'h0);
    @(negedge clk); #1 check("R4 input after two clocks", bus_rdata, 32'hDEAD_BEE0);
    drive_pins(32'h0);

    // interrupt setup: pins 0..3 enabled, pin3 level, pin1 falling, pin2 any edge
    wr(6'h20, 32'h0000_000F);
    wr(6'h34, 32'h0000_0008);
    wr(6'h3C, 32'h0000_0002);
    wr(6'h38, 32'h0000_0004);
    rd_chk("R7 quiet after setup", 6'h24, 32'hFFFF_FFFF, 32'h0);

    drive_pins(32'h1);
    rd_chk("R7 rising latched", 6'h24, 32'hF, 32'h1);
    check("R11 irq on event", {31'd0, irq_o}, 32'h1);
    wr(6'h30, 32'h1);
    rd_chk("R9 ack clears", 6'h24, 32'hF, 32'h0);
    check("R11 irq after ack", {31'd0, irq_o}, 32'h0);
    drive_pins(32'h0);
    rd_chk("R7 falling ignored in rising mode", 6'h24, 32'hF, 32'h0);

    drive_pins(32'h2);
    rd_chk("R7 rising ignored in falling mode", 6'h24, 32'hF, 32'h0);
    drive_pins(32'h0);
    rd_chk("R7 falling latched", 6'h24, 32'hF, 32'h2);
    wr(6'h30, 32'h2);

    drive_pins(32'h4);
    rd_chk("R8 rise latched", 6'h24, 32'hF, 32'h4);
    wr(6'h30, 32'h4);
    rd_chk("R8 ack", 6'h24, 32'hF, 32'h0);
    drive_pins(32'h0);
    rd_chk("R8 fall latched", 6'h24, 32'hF, 32'h4);

    drive_pins(32'h1);
    rd_chk("R9 two pending", 6'h24, 32'hF, 32'h5);
    wr(6'h30, 32'h1);
    rd_chk("R9 selective ack", 6'h24, 32'hF, 32'h4);
    wr(6'h30, 32'hFFFF_FFFF);
    rd_chk("R9 ack all", 6'h24, 32'hFFFF_FFFF, 32'h0);

    drive_pins(32'h9);
    rd_chk("R6 level active-high", 6'h24, 32'hF, 32'h8);
    wr(6'h30, 32'h8);
    rd_chk("R6 ack has no effect", 6'h24, 32'hF, 32'h8);
    drive_pins(32'h1);
    rd_chk("R6 level follows pin", 6'h24, 32'hF, 32'h0);
    wr(6'h3C, 32'h0000_000A);
    rd_chk("R6 level active-low", 6'h24, 32'hF, 32'h8);

    wr(6'h2C, 32'h8);
    rd_chk("R11 masked cleared", 6'h28, 32'hF, 32'h0);
    rd_chk("R11 raw kept under mask", 6'h24, 32'hF, 32'h8);
    check("R11 irq masked", {31'd0, irq_o}, 32'h0);
    wr(6'h2C, 32'h0);
    rd_chk("R11 masked after unmask", 6'h28, 32'hF, 32'h8);
    check("R11 irq unmasked", {31'd0, irq_o}, 32'h1);

    // R10: pin4 edge rising but disabled; pin5 level but disabled
    wr(6'h34, 32'h0000_0028);
    drive_pins(32'h31);
    rd_chk("R10 disabled edge pin", 6'h24, 32'h10, 32'h0);
    rd_chk("R10 disabled level pin", 6'h24, 32'h20, 32'h0);
    wr(6'h20, 32'h0000_001F);
    rd_chk("R10 no retro event", 6'h24, 32'h10, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule